// File: doc/BRIEF.md
# Packed-Column Bit-Serial Systolic Array

This block is a weight-stationary systolic array that multiplies a sparse filter matrix by a data matrix after the columns of the filter matrix have been merged. Each physical array column carries a group of several input-channel streams. Each cell holds one signed 8-bit weight, the only surviving weight of its row inside the merged group, together with a small index that picks which stream of the group it multiplies. Weights are written once through a load port and then stay put while data flows.

Data words enter at the bottom of each column as serial bit streams, least significant bit first, and climb one row per clock. Partial sums travel serially from left to right along each row, one column per clock, and leave at the right edge with a word-boundary flag. Each column's stream is delayed one cycle per column index so that every cell sees its data bit and its incoming partial-sum bit in the same cycle. Each cell multiplies its stationary weight by the serial data with a serial-parallel multiplier and adds the product bits into the passing partial sum with a serial adder. Results are 32 bits wide, or 16 bits wide in a reduced accumulation mode that halves the word period.

Top module: `cc_packed_array`

## Requirements
- R1: A load with `load_en_i` high writes `load_w_i` and `load_sel_i` into the single cell addressed by `load_row_i` and `load_col_i` at the next clock edge; no other cell changes, and no cell changes without a load. Reset clears every cell to weight 0 and index 0.
- R2: Each result word on row r equals, modulo 2^N, the sum over all columns c of w(r,c) times x(c, sel(r,c)), where weights and data are signed two's complement and x(c,g) is the word carried on stream g of column c; the result is sent least significant bit first.
- R3: A cell holding weight 0 adds nothing to its row, whatever its streams carry.
- R4: Only the first 8 bit slots of each input word are used; slots 8 to N-1 are ignored and the cell sign-extends the data from bit 7.
- R5: Bit g of column c on `col_bits_i` is bit `c*GROUP+g`. When column c presents slot 0 of a word with `col_start_i[c]` high at clock edge e+c, row r raises `row_start_o[r]` after edge e+COLS-1+r, and result bit j appears on `row_bit_o[r]` after edge e+COLS-1+r+j.
- R6: With `acc16_i` high (changed only under reset) a word is N=16 slots long and results are modulo 2^16; with it low N=32.
- R7: After a start strobe, words follow back to back every N cycles with no further strobe, and `row_start_o[r]` is high exactly in the first slot of each result word.
- R8: From reset until a column receives its first start strobe, its cells are idle: `row_bit_o` and `row_start_o` stay 0 whatever the stream lines carry.
- R9: Streams of a group not selected by a cell's index have no effect on that cell's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc16_i | input | 1 | 1 selects 16-bit result words, 0 selects 32-bit |
| load_en_i | input | 1 | Weight write enable |
| load_row_i | input | ROW_AW | Row of the cell to write |
| load_col_i | input | COL_AW | Column of the cell to write |
| load_w_i | input | DATA_W | Signed weight to store |
| load_sel_i | input | SEL_W | Stream index to store |
| col_bits_i | input | COLS*GROUP | Serial data bits, GROUP streams per column |
| col_start_i | input | COLS | Word start strobe per column, high with slot 0 |
| row_bit_o | output | ROWS | Serial result bit per row |
| row_start_o | output | ROWS | High in the first slot of each result word |

## Verification
Assertions watch on every cycle that stored weights move only on a load to their own cell, that a word boundary arriving from the left neighbour always meets a boundary in the cell itself, that an idle cell drives nothing, and that the serial adder passes the partial sum through unchanged whenever the product bit and carry are zero. Only the bench scenarios can show the arithmetic: signed products, sign extension over the ignored slots, wrap modulo 2^16 in the short mode, the exact output latency, back-to-back words from a single strobe, and independence from unselected streams, all compared against a packed matrix product computed in the bench from random sparse weights and random data.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic {
    ACC_FULL = 1'b0,
    ACC_HALF = 1'b1
  } acc_mode_e;

  // last slot index of a word for the given mode
  function automatic int unsigned last_slot(input acc_mode_e mode, input int unsigned acc_w);
    return (mode == ACC_HALF) ? (acc_w / 2) - 1 : acc_w - 1;
  endfunction
endpackage

// File: rtl/cc_serial_mul.sv
// Serial-parallel signed multiplier: parallel weight, serial data LSB first.
module cc_serial_mul #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic              x_i,
  input  logic [DATA_W-1:0] w_i,
  output logic              prod_o
);
  localparam int unsigned P_W = DATA_W + 2;

  logic [P_W-1:0] acc_q;
  logic [P_W-1:0] part;
  logic [P_W-1:0] w_ext;

  assign w_ext  = {{2{w_i[DATA_W-1]}}, w_i};
  assign part   = (first_i ? '0 : acc_q) + (x_i ? w_ext : '0);
  assign prod_o = en_i & part[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= {part[P_W-1], part[P_W-1:1]};
    else           acc_q <= '0;
  end
endmodule

// File: rtl/cc_serial_add.sv
// Bit-serial adder with registered sum; carry cleared at a word boundary.
module cc_serial_add (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o
);
  logic c_q;
  logic c_eff;
  logic s;
  logic co;

  assign c_eff = first_i ? 1'b0 : c_q;
  assign s     = a_i ^ b_i ^ c_eff;
  assign co    = (a_i & b_i) | (c_eff & (a_i ^ b_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      sum_o <= en_i & s;
      c_q   <= en_i & co;
    end
  end

  // R3: zero product bit with no pending carry leaves the partial sum untouched
  a_r3_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !a_i && (first_i || !c_q)) |=> (sum_o == $past(b_i)));
endmodule

// File: rtl/cc_cell.sv
module cc_cell
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned GROUP  = 4,
  parameter int unsigned SEL_W  = $clog2(GROUP),
  parameter int unsigned CNT_W  = $clog2(ACC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc16_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_w_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [GROUP-1:0]  x_i,
  input  logic              start_i,
  input  logic              psum_i,
  input  logic              pstart_i,
  output logic              psum_o,
  output logic              pstart_o
);
  logic [DATA_W-1:0] w_q;
  logic [SEL_W-1:0]  sel_q;
  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sign_q;
  logic              active;
  logic [CNT_W-1:0]  slot;
  logic [CNT_W-1:0]  last;
  logic              first;
  logic              x_sel;
  logic              x_eff;
  logic              prod;

  assign active = start_i | run_q;
  assign slot   = start_i ? '0 : cnt_q;
  assign last   = CNT_W'(last_slot(acc_mode_e'(acc16_i), ACC_W));
  assign first  = active && (slot == '0);
  assign x_sel  = x_i[sel_q];
  assign x_eff  = (slot < CNT_W'(DATA_W)) ? x_sel : sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      sel_q <= '0;
    end else if (ld_i) begin
      w_q   <= ld_w_i;
      sel_q <= ld_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      sign_q   <= 1'b0;
      pstart_o <= 1'b0;
    end else begin
      run_q    <= active;
      pstart_o <= first;
      if (!active || slot >= last) cnt_q <= '0;
      else                         cnt_q <= slot + 1'b1;
      if (active && slot == CNT_W'(DATA_W - 1)) sign_q <= x_sel;
    end
  end

  cc_serial_mul #(.DATA_W(DATA_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active),
    .first_i(first),
    .x_i    (x_eff),
    .w_i    (w_q),
    .prod_o (prod)
  );

  cc_serial_add u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active),
    .first_i(first),
    .a_i    (prod),
    .b_i    (psum_i),
    .sum_o  (psum_o)
  );

  a_r1_weight_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> ($stable(w_q) && $stable(sel_q)));

  a_r1_weight_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> ((w_q == $past(ld_w_i)) && (sel_q == $past(ld_sel_i))));

  // R5: boundaries along a row stay one cycle apart per column
  a_r5_row_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstart_i |-> first);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!psum_o && !pstart_o));
endmodule

// File: rtl/cc_packed_array.sv
module cc_packed_array #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 4,
  parameter int unsigned GROUP  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned SEL_W  = $clog2(GROUP),
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned COL_AW = $clog2(COLS),
  localparam int unsigned CNT_W  = $clog2(ACC_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc16_i,
  input  logic                  load_en_i,
  input  logic [ROW_AW-1:0]     load_row_i,
  input  logic [COL_AW-1:0]     load_col_i,
  input  logic [DATA_W-1:0]     load_w_i,
  input  logic [SEL_W-1:0]      load_sel_i,
  input  logic [COLS*GROUP-1:0] col_bits_i,
  input  logic [COLS-1:0]       col_start_i,
  output logic [ROWS-1:0]       row_bit_o,
  output logic [ROWS-1:0]       row_start_o
);
  logic [GROUP-1:0] dbit   [ROWS][COLS];
  logic             dstart [ROWS][COLS];
  logic             ps     [ROWS][COLS+1];
  logic             pst    [ROWS][COLS+1];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign ps[r][0]       = 1'b0;
    assign pst[r][0]      = 1'b0;
    assign row_bit_o[r]   = ps[r][COLS];
    assign row_start_o[r] = pst[r][COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic ld;

      if (r == 0) begin : g_entry
        assign dbit[r][c]   = col_bits_i[c*GROUP +: GROUP];
        assign dstart[r][c] = col_start_i[c];
      end else begin : g_climb
        logic [GROUP-1:0] bits_q;
        logic             start_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            bits_q  <= '0;
            start_q <= 1'b0;
          end else begin
            bits_q  <= dbit[r-1][c];
            start_q <= dstart[r-1][c];
          end
        end
        assign dbit[r][c]   = bits_q;
        assign dstart[r][c] = start_q;
      end

      assign ld = load_en_i && (load_row_i == ROW_AW'(r)) && (load_col_i == COL_AW'(c));

      cc_cell #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W),
        .GROUP (GROUP),
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
      ) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .acc16_i (acc16_i),
        .ld_i    (ld),
        .ld_w_i  (load_w_i),
        .ld_sel_i(load_sel_i),
        .x_i     (dbit[r][c]),
        .start_i (dstart[r][c]),
        .psum_i  (ps[r][c]),
        .pstart_i(pst[r][c]),
        .psum_o  (ps[r][c+1]),
        .pstart_o(pst[r][c+1])
      );
    end
  end
endmodule

// File: tb/cc_packed_array_tb.sv
`timescale 1ns/1ps
module cc_packed_array_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int GROUP = 4;
  localparam int ACC_W = 32;
  localparam int MAXW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc16 = 1'b0;
  logic load_en = 1'b0;
  logic [1:0] load_row = '0;
  logic [1:0] load_col = '0;
  logic [7:0] load_w = '0;
  logic [1:0] load_sel = '0;
  logic [COLS*GROUP-1:0] col_bits = '0;
  logic [COLS-1:0] col_start = '0;
  logic [ROWS-1:0] row_bit;
  logic [ROWS-1:0] row_start;

  int n_run = 0;
  int n_fail = 0;

  logic signed [7:0] wm [ROWS][COLS];
  int                sm [ROWS][COLS];
  logic signed [7:0] xd [MAXW][COLS][GROUP];

  always #2.5 clk = ~clk;

  cc_packed_array #(.ROWS(ROWS), .COLS(COLS), .GROUP(GROUP), .DATA_W(8), .ACC_W(ACC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc16_i(acc16),
    .load_en_i(load_en), .load_row_i(load_row), .load_col_i(load_col),
    .load_w_i(load_w), .load_sel_i(load_sel),
    .col_bits_i(col_bits), .col_start_i(col_start),
    .row_bit_o(row_bit), .row_start_o(row_start)
  );

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input bit half);
    @(negedge clk);
    rst_n = 1'b0; acc16 = half; col_bits = '0; col_start = '0; load_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin wm[r][c] = 0; sm[r][c] = 0; end
  endtask

  // R8: streams toggle without strobes, outputs must stay quiet
  task automatic check_idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(row_bit == '0 && row_start == '0, "R8 idle outputs", {row_start, row_bit}, 0);
      col_bits = (COLS*GROUP)'($urandom);
    end
    @(negedge clk);
    col_bits = '0;
  endtask

  task automatic set_cell(input int r, input int c, input logic signed [7:0] w, input int s);
    wm[r][c] = w; sm[r][c] = s;
    @(negedge clk);
    load_en = 1'b1; load_row = 2'(r); load_col = 2'(c); load_w = w; load_sel = 2'(s);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic load_random(input int zero_pct);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        set_cell(r, c, (($urandom % 100) < zero_pct) ? 8'sd0 : 8'($urandom), int'($urandom % GROUP));
  endtask

  // dmode 0: random data, 1: all -128
  task automatic run_burst(input int nw, input int dmode, input string tag);
    int n;
    logic [31:0] got [MAXW][ROWS];
    bit          flag_ok [MAXW][ROWS];
    logic [GROUP-1:0] b;
    n = acc16 ? ACC_W/2 : ACC_W;
    for (int k = 0; k < nw; k++)
      for (int c = 0; c < COLS; c++)
        for (int g = 0; g < GROUP; g++)
          xd[k][c][g] = (dmode == 1) ? -8'sd128 : 8'($urandom);
    for (int k = 0; k < nw; k++)
      for (int r = 0; r < ROWS; r++) begin got[k][r] = '0; flag_ok[k][r] = 1'b1; end
    for (int t = 0; t < nw*n + COLS + ROWS + 2; t++) begin
      @(negedge clk);
      for (int r = 0; r < ROWS; r++) begin
        int ls;
        ls = t - COLS - r;
        if (ls >= 0 && ls < nw*n) begin
          got[ls/n][r][ls%n] = row_bit[r];
          if (row_start[r] != ((ls % n) == 0)) flag_ok[ls/n][r] = 1'b0;
        end
      end
      for (int c = 0; c < COLS; c++) begin
        int ls;
        ls = t - c;
        if (ls >= 0 && ls < nw*n) begin
          for (int g = 0; g < GROUP; g++)
            b[g] = ((ls % n) < 8) ? xd[ls/n][c][g][ls%n] : 1'($urandom);
          col_bits[c*GROUP +: GROUP] = b;
          col_start[c] = (ls == 0);
        end else begin
          col_bits[c*GROUP +: GROUP] = '0;
          col_start[c] = 1'b0;
        end
      end
    end
    for (int k = 0; k < nw; k++)
      for (int r = 0; r < ROWS; r++) begin
        int exp;
        logic [31:0] e;
        exp = 0;
        for (int c = 0; c < COLS; c++) exp += int'(wm[r][c]) * int'(xd[k][c][sm[r][c]]);
        e = (n == 32) ? 32'(exp) : {16'h0, exp[15:0]};
        check(got[k][r] == e, $sformatf("%s row %0d word %0d value", tag, r, k), got[k][r], e);
        check(flag_ok[k][r], $sformatf("R5 R7 row %0d word %0d start flag timing", r, k), 0, 1);
      end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1357));
    do_reset(1'b0);
    check_idle(6);

    // R2 R4 R5 R7 R9: random sparse weights, 32-bit words back to back
    load_random(50);
    run_burst(3, 0, "R2 R4 R9");

    // R3: empty cells contribute nothing
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_cell(r, c, 8'sd0, int'($urandom % GROUP));
    run_burst(2, 0, "R3 all zero");

    // R2 most negative corner: 4 * 16384
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_cell(r, c, -8'sd128, r % GROUP);
    run_burst(1, 1, "R2 min corner");

    // R1: single cell rewrite, neighbours keep their values
    set_cell(1, 2, 8'sd5, 3);
    set_cell(3, 0, 8'sd0, 1);
    run_burst(2, 0, "R1 single reload");

    // R9: every cell picks a distinct stream per column
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_cell(r, c, 8'($urandom | 1), (r + c) % GROUP);
    run_burst(2, 0, "R9 unselected ignored");

    // R6: short words, back to back from one strobe
    do_reset(1'b1);
    check_idle(4);
    load_random(30);
    run_burst(4, 0, "R6 R7 half mode");
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) set_cell(r, c, -8'sd128, c % GROUP);
    run_burst(2, 1, "R6 wrap to zero");

    for (int i = 0; i < 6; i++) begin
      do_reset(1'(i % 2));
      load_random(40 + 10 * (i % 3));
      run_burst(3, 0, "R2 R4 R6 random round");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule